// File: doc/BRIEF.md
# Privilege-Gated Hash Store/Check Controller

This block decides whether a return-address hash operation takes effect. It holds two 64-bit control registers: an execution-control register and a hypervisor-level control register. For each security aspect, those registers carry four enable bits. The block selects among them by priority, using the processor's current privilege state: problem state, hypervisor state and secure state.

The two registers are reached through a control-register access port. Each register has two numbers:

- A full-access number, which is privilege-checked.
- A read-only alias number, which lies 16 below the full-access number and can be used from any privilege level.

A hash request arrives with a precomputed 64-bit digest and the 64-bit value already fetched from memory. The request is either a store or a check. It also states whether it uses the privileged key or the non-privileged key.

- An enabled store presents the digest for writing to memory.
- An enabled check raises a trap pulse when the fetched value differs from the digest.
- A disabled request completes silently.

Every accepted request produces a done pulse. The request side follows valid/ready rules, but `req_ready` is held high: a request is accepted in every cycle where `req_valid` is high, and the block never applies back-pressure. The store output, `store_valid` with `store_data`, is a one-cycle qualifier. Memory is expected to take the store in that cycle, with no ready to wait on.

Top module: `hashgate_ctl`

## Requirements
- R1: After reset both registers read as zero, and `done`, `store_valid`, `trap`, `csr_priv_err` and `csr_rdata` are low or zero.
- R2: With `st_user`=0, a write to number 0x33C updates the execution-control register. A read of 0x33C returns its full 64-bit value on `csr_rdata` in the cycle after the read strobe.
- R3: The execution-control register at 0x33C may be accessed only with `st_user`=0. The hypervisor register at 0x1D7 may be accessed only with `st_hyp`=1 and `st_user`=0. Any other read or write of these numbers gives a one-cycle `csr_priv_err` pulse in the next cycle, leaves the register unchanged, and reads as zero.
- R4: Reads of the alias numbers 0x32C (execution control) and 0x1C7 (hypervisor) are allowed in any privilege state. They return register bits [31:0], counted from the LSB, with bits [63:32] zero.
- R5: Writes to the alias numbers change neither register and raise no `csr_priv_err`.
- R6: Bit positions are counted with LSB = 0. For aspect k:
  - the execution-control register holds the supervisor enable at bit 63−k and the problem-state enable at bit 31−k;
  - the hypervisor register holds the hypervisor enable at bit 63−k and the forced-enforce bit at bit 31−k.
  Requests with `req_privkey`=0 use aspect 5. Requests with `req_privkey`=1 use aspect 6. The bits of any other aspect have no effect.
- R7: With `st_user`=1, a request is enabled when the aspect's problem-state enable bit or its forced-enforce bit is set.
- R8: With `st_user`=0 and `st_hyp`=0, a request is enabled when the supervisor enable bit or the forced-enforce bit is set.
- R9: With `st_user`=0 and `st_hyp`=1, a request is enabled by the hypervisor enable bit alone when `st_secure`=0. It is always enabled when `st_secure`=1.
- R10: An enabled store request gives `store_valid`=1 with `store_data` equal to the digest, one cycle after acceptance.
- R11: An enabled check request gives `trap`=1 one cycle after acceptance exactly when `req_loaded` differs from `req_digest`.
- R12: A disabled request gives neither a store nor a trap. Every accepted request, enabled or not, gives `done`=1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 10 | Control-register number |
| csr_wen | input | 1 | Write strobe |
| csr_ren | input | 1 | Read strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, valid the cycle after `csr_ren` |
| csr_priv_err | output | 1 | Privilege violation pulse |
| st_user | input | 1 | Problem-state bit |
| st_hyp | input | 1 | Hypervisor-state bit |
| st_secure | input | 1 | Secure-state bit |
| req_valid | input | 1 | Hash request valid |
| req_ready | output | 1 | Request ready (always high) |
| req_store | input | 1 | 1 = store, 0 = check |
| req_privkey | input | 1 | 1 = privileged key (aspect 6), 0 = aspect 5 |
| req_digest | input | 64 | Computed digest |
| req_loaded | input | 64 | Value fetched from memory |
| store_valid | output | 1 | Digest should be written to memory |
| store_data | output | 64 | Digest to write |
| trap | output | 1 | Hash mismatch trap pulse |
| done | output | 1 | Request completion pulse |

## Verification
Every result the block produces is registered once.

- `done`, `store_valid`, `store_data` and `trap` belong to the request accepted at the previous rising edge.
- `csr_rdata` and `csr_priv_err` belong to the access strobed at the previous edge.

The bench drives each stimulus at a falling edge and holds it across exactly one rising edge. At the next falling edge it withdraws the stimulus and samples the outputs, so each sample lands in the single cycle where that result is due. A sweep covers every enable-bit pattern of both aspects, with the other aspect loaded with the complement pattern, under all eight privilege-state combinations, for store and check and for match and mismatch.

// File: rtl/hg_pkg.sv
package hg_pkg;

  // Which register, and which view of it, a control-register number selects.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_CTL_RO,
    SEL_HYP,
    SEL_HYP_RO
  } csr_sel_e;

  // Returned by the policy unit for the selected aspect.
  typedef struct packed {
    logic sup_en;
    logic usr_en;
    logic hyp_en;
    logic frc_en;
  } aspect_bits_t;

endpackage

// File: rtl/hg_ctlregs.sv
module hg_ctlregs
  import hg_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int AW        = 10,
  parameter int CTL_NUM   = 'h33C,
  parameter int HYP_NUM   = 'h1D7,
  parameter int ALIAS_GAP = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   csr_addr,
  input  logic            csr_wen,
  input  logic            csr_ren,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            st_user,
  input  logic            st_hyp,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_priv_err,
  output logic [XLEN-1:0] ctl_q,
  output logic [XLEN-1:0] hyp_q
);

  localparam int HALF = XLEN / 2;
  localparam logic [AW-1:0] CTL_FULL = AW'(CTL_NUM);
  localparam logic [AW-1:0] CTL_RO   = AW'(CTL_NUM - ALIAS_GAP);
  localparam logic [AW-1:0] HYP_FULL = AW'(HYP_NUM);
  localparam logic [AW-1:0] HYP_RO   = AW'(HYP_NUM - ALIAS_GAP);

  csr_sel_e        sel;
  logic            allowed;
  logic            access;
  logic            err_d;
  logic [XLEN-1:0] rdata_d;

  always_comb begin
    if      (csr_addr == CTL_FULL) sel = SEL_CTL;
    else if (csr_addr == CTL_RO)   sel = SEL_CTL_RO;
    else if (csr_addr == HYP_FULL) sel = SEL_HYP;
    else if (csr_addr == HYP_RO)   sel = SEL_HYP_RO;
    else                           sel = SEL_NONE;
  end

  // Full-access views are privilege checked; aliases and unknown numbers are not.
  always_comb begin
    case (sel)
      SEL_CTL: allowed = !st_user;
      SEL_HYP: allowed = st_hyp && !st_user;
      default: allowed = 1'b1;
    endcase
  end

  assign access = csr_wen || csr_ren;
  assign err_d  = access && !allowed;

  always_comb begin
    rdata_d = '0;
    if (csr_ren && allowed) begin
      case (sel)
        SEL_CTL:    rdata_d = ctl_q;
        SEL_HYP:    rdata_d = hyp_q;
        SEL_CTL_RO: rdata_d = {{HALF{1'b0}}, ctl_q[HALF-1:0]};
        SEL_HYP_RO: rdata_d = {{HALF{1'b0}}, hyp_q[HALF-1:0]};
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      hyp_q        <= '0;
      csr_rdata    <= '0;
      csr_priv_err <= 1'b0;
    end else begin
      if (csr_wen && allowed && sel == SEL_CTL) ctl_q <= csr_wdata;
      if (csr_wen && allowed && sel == SEL_HYP) hyp_q <= csr_wdata;
      csr_rdata    <= rdata_d;
      csr_priv_err <= err_d;
    end
  end

  // R3: a refused access leaves both registers untouched
  a_r3_err_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    csr_priv_err |-> ($stable(ctl_q) && $stable(hyp_q)));

  // R5: alias writes never change state
  a_r5_alias_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wen && (csr_addr == CTL_RO || csr_addr == HYP_RO))
      |=> ($stable(ctl_q) && $stable(hyp_q) && !csr_priv_err));

  // R4: alias reads return a zero upper half
  a_r4_alias_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_ren && (csr_addr == CTL_RO || csr_addr == HYP_RO))
      |=> (csr_rdata[XLEN-1:HALF] == '0));

endmodule

// File: rtl/hg_policy.sv
module hg_policy
  import hg_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int ASPECT_NP = 5,
  parameter int ASPECT_P  = 6
) (
  input  logic [XLEN-1:0] ctl_i,
  input  logic [XLEN-1:0] hyp_i,
  input  logic            st_user,
  input  logic            st_hyp,
  input  logic            st_secure,
  input  logic            privkey,
  output logic            enable_o
);

  localparam int NKEY = 2;

  logic [NKEY-1:0] en_k;
  logic            unused_bits;

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    localparam int ASP    = (g == 0) ? ASPECT_NP : ASPECT_P;
    localparam int POS_HI = XLEN - 1 - ASP;
    localparam int POS_LO = XLEN / 2 - 1 - ASP;
    aspect_bits_t b;
    logic         en;

    assign b.sup_en = ctl_i[POS_HI];
    assign b.usr_en = ctl_i[POS_LO];
    assign b.hyp_en = hyp_i[POS_HI];
    assign b.frc_en = hyp_i[POS_LO];

    // Priority: problem state, then supervisor, then hypervisor, then secure.
    assign en = st_user    ? (b.usr_en | b.frc_en) :
                !st_hyp    ? (b.sup_en | b.frc_en) :
                !st_secure ? b.hyp_en : 1'b1;
    assign en_k[g] = en;
  end

  assign enable_o    = en_k[privkey];
  assign unused_bits = ^{ctl_i, hyp_i};

endmodule

// File: rtl/hg_exec.sv
module hg_exec #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            is_store,
  input  logic            enable,
  input  logic [XLEN-1:0] digest,
  input  logic [XLEN-1:0] loaded,
  output logic            done,
  output logic            store_valid,
  output logic [XLEN-1:0] store_data,
  output logic            trap
);

  logic do_store;
  logic do_check;

  assign do_store = fire && enable && is_store;
  assign do_check = fire && enable && !is_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      store_valid <= 1'b0;
      store_data  <= '0;
      trap        <= 1'b0;
    end else begin
      done        <= fire;
      store_valid <= do_store;
      trap        <= do_check && (loaded != digest);
      if (do_store) store_data <= digest;
    end
  end

  // R12: completion follows every accepted request by one cycle
  a_r12_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> done);

  // R12: no completion without a request
  a_r12_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !done);

  // R11: a trap only comes from a check request
  a_r11_trap_from_check: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (done && !store_valid && $past(!is_store)));

  // R10: a store only comes from a store request
  a_r10_store_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid |-> (done && $past(is_store)));

endmodule

// File: rtl/hashgate_ctl.sv
module hashgate_ctl #(
  parameter int XLEN      = 64,
  parameter int AW        = 10,
  parameter int CTL_NUM   = 'h33C,
  parameter int HYP_NUM   = 'h1D7,
  parameter int ALIAS_GAP = 16,
  parameter int ASPECT_NP = 5,
  parameter int ASPECT_P  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   csr_addr,
  input  logic            csr_wen,
  input  logic            csr_ren,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_priv_err,
  input  logic            st_user,
  input  logic            st_hyp,
  input  logic            st_secure,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_store,
  input  logic            req_privkey,
  input  logic [XLEN-1:0] req_digest,
  input  logic [XLEN-1:0] req_loaded,
  output logic            store_valid,
  output logic [XLEN-1:0] store_data,
  output logic            trap,
  output logic            done
);

  logic [XLEN-1:0] ctl_q;
  logic [XLEN-1:0] hyp_q;
  logic            enable;
  logic            fire;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;

  hg_ctlregs #(
    .XLEN(XLEN), .AW(AW), .CTL_NUM(CTL_NUM),
    .HYP_NUM(HYP_NUM), .ALIAS_GAP(ALIAS_GAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .csr_addr(csr_addr), .csr_wen(csr_wen), .csr_ren(csr_ren),
    .csr_wdata(csr_wdata), .st_user(st_user), .st_hyp(st_hyp),
    .csr_rdata(csr_rdata), .csr_priv_err(csr_priv_err),
    .ctl_q(ctl_q), .hyp_q(hyp_q)
  );

  hg_policy #(
    .XLEN(XLEN), .ASPECT_NP(ASPECT_NP), .ASPECT_P(ASPECT_P)
  ) u_policy (
    .ctl_i(ctl_q), .hyp_i(hyp_q),
    .st_user(st_user), .st_hyp(st_hyp), .st_secure(st_secure),
    .privkey(req_privkey), .enable_o(enable)
  );

  hg_exec #(.XLEN(XLEN)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .is_store(req_store), .enable(enable),
    .digest(req_digest), .loaded(req_loaded),
    .done(done), .store_valid(store_valid),
    .store_data(store_data), .trap(trap)
  );

endmodule

// File: tb/test_hashgate_ctl.sv
`timescale 1ns/1ps
module test_hashgate_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  csr_addr = '0;
  logic        csr_wen = 1'b0, csr_ren = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_priv_err;
  logic        st_user = 1'b0, st_hyp = 1'b0, st_secure = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_privkey = 1'b0;
  logic        req_ready;
  logic [63:0] req_digest = '0, req_loaded = '0;
  logic        store_valid, trap, done;
  logic [63:0] store_data;

  int nchk = 0;
  int nerr = 0;

  localparam logic [9:0] N_CTL = 10'h33C, N_CTL_RO = 10'h32C;
  localparam logic [9:0] N_HYP = 10'h1D7, N_HYP_RO = 10'h1C7;

  always #4 clk = ~clk;

  hashgate_ctl i_hashgate_ctl (
    .clk(clk), .rst_n(rst_n),
    .csr_addr(csr_addr), .csr_wen(csr_wen), .csr_ren(csr_ren),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_priv_err(csr_priv_err),
    .st_user(st_user), .st_hyp(st_hyp), .st_secure(st_secure),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_privkey(req_privkey), .req_digest(req_digest), .req_loaded(req_loaded),
    .store_valid(store_valid), .store_data(store_data), .trap(trap), .done(done)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_state(input bit pr, input bit hv, input bit s);
    st_user = pr; st_hyp = hv; st_secure = s;
  endtask

  task automatic csr_acc(input logic [9:0] a, input bit wr, input logic [63:0] d,
                         output logic [63:0] rd, output bit err);
    @(negedge clk);
    csr_addr = a; csr_wen = wr; csr_ren = !wr; csr_wdata = d;
    @(negedge clk);
    rd = csr_rdata; err = csr_priv_err;
    csr_wen = 1'b0; csr_ren = 1'b0;
  endtask

  function automatic bit exp_en(input logic [63:0] c, input logic [63:0] h,
                                input bit pr, input bit hv, input bit s, input bit pk);
    int a;
    a = pk ? 6 : 5;
    if (pr)  return c[31-a] | h[31-a];
    if (!hv) return c[63-a] | h[31-a];
    if (!s)  return h[63-a];
    return 1'b1;
  endfunction

  initial begin
    #(8 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    bit          err;

    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk("R1 outputs at reset", {csr_rdata, 60'd0, csr_priv_err, done, store_valid, trap}, '0);
    rst_n = 1'b1;
    set_state(0, 1, 0);
    csr_acc(N_CTL, 0, '0, rd, err);
    chk("R1 ctl reset", {rd, 63'd0, err}, '0);
    csr_acc(N_HYP, 0, '0, rd, err);
    chk("R1 hyp reset", {rd, 63'd0, err}, '0);

    // R2: supervisor write and read-back
    set_state(0, 0, 0);
    csr_acc(N_CTL, 1, 64'hDEAD_BEEF_0123_4567, rd, err);
    chk("R2 write err", {127'd0, err}, '0);
    csr_acc(N_CTL, 0, '0, rd, err);
    chk("R2 read-back", {rd, 63'd0, err}, {64'hDEAD_BEEF_0123_4567, 64'd0});

    // R3: refused accesses
    set_state(1, 0, 0);
    csr_acc(N_CTL, 1, 64'h1111, rd, err);
    chk("R3 user write ctl err", {127'd0, err}, 128'd1);
    csr_acc(N_CTL, 0, '0, rd, err);
    chk("R3 user read ctl", {rd, 63'd0, err}, 128'd1);
    set_state(0, 0, 0);
    csr_acc(N_HYP, 1, 64'h2222, rd, err);
    chk("R3 sup write hyp err", {127'd0, err}, 128'd1);
    csr_acc(N_CTL, 0, '0, rd, err);
    chk("R3 ctl unchanged", {rd, 63'd0, err}, {64'hDEAD_BEEF_0123_4567, 64'd0});
    set_state(0, 1, 0);
    csr_acc(N_HYP, 0, '0, rd, err);
    chk("R3 hyp unchanged", {rd, 63'd0, err}, '0);
    csr_acc(N_HYP, 1, 64'hCAFE_F00D_89AB_CDEF, rd, err);
    chk("R3 hyp write ok", {127'd0, err}, '0);

    // R4: alias reads from problem state
    set_state(1, 0, 0);
    csr_acc(N_CTL_RO, 0, '0, rd, err);
    chk("R4 ctl alias", {rd, 63'd0, err}, {64'h0000_0000_0123_4567, 64'd0});
    csr_acc(N_HYP_RO, 0, '0, rd, err);
    chk("R4 hyp alias", {rd, 63'd0, err}, {64'h0000_0000_89AB_CDEF, 64'd0});

    // R5: alias writes ignored
    csr_acc(N_CTL_RO, 1, 64'h5555, rd, err);
    chk("R5 ctl alias write err", {127'd0, err}, '0);
    csr_acc(N_HYP_RO, 1, 64'h6666, rd, err);
    chk("R5 hyp alias write err", {127'd0, err}, '0);
    set_state(0, 1, 0);
    csr_acc(N_CTL, 0, '0, rd, err);
    chk("R5 ctl kept", rd, 64'hDEAD_BEEF_0123_4567);
    csr_acc(N_HYP, 0, '0, rd, err);
    chk("R5 hyp kept", rd, 64'hCAFE_F00D_89AB_CDEF);

    // R6..R12: sweep enable patterns, privilege states, ops and match/mismatch
    for (int pk = 0; pk < 2; pk++) begin
      for (int pat = 0; pat < 16; pat++) begin
        int          a, o;
        logic [63:0] c, h;
        a = pk ? 6 : 5;
        o = pk ? 5 : 6;
        c = '0; h = '0;
        c[63-a] = pat[0]; c[31-a] = pat[1];
        h[63-a] = pat[2]; h[31-a] = pat[3];
        // R6: the other aspect carries the complement pattern
        c[63-o] = !pat[0]; c[31-o] = !pat[1];
        h[63-o] = !pat[2]; h[31-o] = !pat[3];
        set_state(0, 1, 0);
        csr_acc(N_CTL, 1, c, rd, err);
        csr_acc(N_HYP, 1, h, rd, err);
        for (int st = 0; st < 8; st++) begin
          for (int op = 0; op < 2; op++) begin
            for (int mm = 0; mm < 2; mm++) begin
              logic [63:0] dg;
              bit          en, pr, hv, s;
              string       tag;
              pr = st[2]; hv = st[1]; s = st[0];
              dg = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(pat) << 40) ^ (64'(st) << 8) ^ 64'(pk);
              en = exp_en(c, h, pr, hv, s, pk[0]);
              @(negedge clk);
              set_state(pr, hv, s);
              req_valid = 1'b1; req_store = op[0]; req_privkey = pk[0];
              req_digest = dg; req_loaded = mm[0] ? (dg ^ 64'h10) : dg;
              @(negedge clk);
              req_valid = 1'b0;
              if (pr)       tag = "R7";
              else if (!hv) tag = "R8";
              else          tag = "R9";
              if (!en)      tag = {tag, " R12 disabled R6"};
              else if (op)  tag = {tag, " R10 store R6"};
              else          tag = {tag, " R11 check R6"};
              chk(tag,
                  {done, store_valid, trap, 61'd0, (store_valid ? store_data : 64'd0)},
                  {1'b1, en && op == 1, en && op == 0 && mm == 1, 61'd0,
                   ((en && op == 1) ? dg : 64'd0)});
            end
          end
        end
      end
    end

    // R12: done is a single-cycle pulse
    @(negedge clk);
    chk("R12 done idle", {125'd0, done, store_valid, trap}, '0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule